// File: doc/BRIEF.md
# Strobed Port Handshake Controller

This block runs the handshake for a single 8-bit peripheral port whose transfers are paced by strobes instead of plain reads and writes. A direction input chooses one of two roles. As a latched input, the port captures peripheral data while the strobe line is low and sets a buffer-full flag. It raises an interrupt once the strobe returns high, and the CPU read sequence clears the interrupt and then the flag. As a latched output, a CPU write fills the output latch and pulls the active-low buffer-full flag down. The peripheral's acknowledge releases that flag, and an interrupt then asks the CPU for the next byte.

All four control lines (strobe, acknowledge, CPU read, CPU write) can change at any time relative to the system clock. Each passes through a two-flop synchronizer and a register that holds its previous value, and edges are found by comparing the two. An interrupt-enable bit is written through its own strobe. It gates both interrupt sources without disturbing the buffer flags. Address decode and the bidirectional mode belong to the surrounding logic.

Top module: `strobe_port_hs`

## Requirements
- R1: After reset, ibf is 0, obf_n is 1, intr is 0, ie_q is 0, and both rd_data and pin_out are 0.
- R2: In input mode, every clock cycle in which the synchronized strobe is low copies pin_in into the input latch, which is visible on rd_data.
- R3: In input mode, ibf is set while the synchronized strobe is low and cleared on a rising edge of rd_n. When a low strobe and a read rising edge are seen in the same cycle, ibf stays set.
- R4: In input mode, intr rises when the strobe is high, ibf is 1, ie_q is 1 and rd_n has been high for two synchronized samples. A falling edge of rd_n clears it.
- R5: A second strobe while ibf is already 1 overwrites the input latch with the new pin_in value and leaves ibf at 1.
- R6: In output mode, a rising edge of wr_n loads cpu_wdata into the output latch driven on pin_out and drives obf_n to 0.
- R7: In output mode, a synchronized low on ack_n returns obf_n to 1. A write rising edge seen in the same cycle wins, so obf_n is 0 for that cycle and returns to 1 on the next cycle if ack_n is still low.
- R8: In output mode, intr rises when ack_n is high, obf_n is 1, ie_q is 1 and wr_n has been high for two synchronized samples. This includes the idle state after entering output mode. A falling edge of wr_n clears it.
- R9: A cycle with ie_we high loads ie_d into ie_q. Writing 0 brings intr to 0 on the next clock edge and leaves ibf and obf_n unchanged.
- R10: dir_out is 0 for input and 1 for output. A change of dir_out clears ibf, releases obf_n and clears intr. In output mode ibf stays 0 and the strobe leaves rd_data untouched. In input mode obf_n stays 1.
- R11: A level change on stb_n, ack_n, rd_n or wr_n takes effect on the flags at the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | Port role: 0 latched input, 1 latched output |
| stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| rd_n | input | 1 | CPU read of this port, active low, asynchronous |
| wr_n | input | 1 | CPU write of this port, active low, asynchronous |
| ie_we | input | 1 | Write strobe for the interrupt-enable bit |
| ie_d | input | 1 | Value written to the interrupt-enable bit |
| pin_in | input | 8 | Data from the peripheral |
| cpu_wdata | input | 8 | Data from the CPU for output mode |
| rd_data | output | 8 | Input latch contents returned to the CPU |
| pin_out | output | 8 | Output latch driven to the peripheral |
| ibf | output | 1 | Input buffer full, active high |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request, active high |
| ie_q | output | 1 | Current interrupt-enable bit |

## Verification
Two functions can collide in one cycle. In input mode, a fresh strobe can meet the read rising edge that would empty the buffer. In output mode, a write rising edge can meet a held-low acknowledge. The bench provokes each collision by moving both pins at the same falling clock edge. Both lines have the same synchronizer depth, so both events reach the flag logic in the same cycle. The bench then judges the flag cycle by cycle: ibf must stay set, and obf_n must be low for exactly one cycle before the acknowledge releases it.

// File: rtl/strobe_port_hs.sv
module strobe_port_hs #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_out,
  input  logic         stb_n,
  input  logic         ack_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic         ie_we,
  input  logic         ie_d,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] rd_data,
  output logic [W-1:0] pin_out,
  output logic         ibf,
  output logic         obf_n,
  output logic         intr,
  output logic         ie_q
);

  localparam int NL = 4;

  logic [NL-1:0]            raw;
  logic [SYNC-1:0][NL-1:0]  sh;
  logic [NL-1:0]            cur, prv;

  assign raw = {wr_n, rd_n, ack_n, stb_n};
  assign cur = sh[SYNC-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh  <= '1;
      prv <= '1;
    end else begin
      sh  <= {sh[SYNC-2:0], raw};
      prv <= cur;
    end

  logic s_stb, s_ack, s_rd, s_wr, p_rd, p_wr;
  assign s_stb = cur[0];
  assign s_ack = cur[1];
  assign s_rd  = cur[2];
  assign s_wr  = cur[3];
  assign p_rd  = prv[2];
  assign p_wr  = prv[3];

  logic rd_rise, rd_fall, wr_rise, wr_fall, ie_off;
  assign rd_rise = s_rd & ~p_rd;
  assign rd_fall = ~s_rd & p_rd;
  assign wr_rise = s_wr & ~p_wr;
  assign wr_fall = ~s_wr & p_wr;
  assign ie_off  = ie_we & ~ie_d;

  logic [W-1:0] in_lat, out_lat;
  logic ibf_q, obf_q, intr_q, dir_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_lat  <= '0;
      out_lat <= '0;
      ibf_q   <= 1'b0;
      obf_q   <= 1'b1;
      intr_q  <= 1'b0;
      ie_q    <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      dir_q <= dir_out;
      if (ie_we) ie_q <= ie_d;
      if (dir_out != dir_q) begin
        ibf_q  <= 1'b0;
        obf_q  <= 1'b1;
        intr_q <= 1'b0;
      end else if (!dir_out) begin
        if (!s_stb) in_lat <= pin_in;
        if (!s_stb)       ibf_q <= 1'b1;
        else if (rd_rise) ibf_q <= 1'b0;
        if (rd_fall || ie_off) intr_q <= 1'b0;
        else if (s_stb && ibf_q && ie_q && s_rd && p_rd) intr_q <= 1'b1;
      end else begin
        if (wr_rise) out_lat <= cpu_wdata;
        if (wr_rise)     obf_q <= 1'b0;
        else if (!s_ack) obf_q <= 1'b1;
        if (wr_fall || ie_off) intr_q <= 1'b0;
        else if (s_ack && obf_q && ie_q && s_wr && p_wr) intr_q <= 1'b1;
      end
    end

  assign rd_data = in_lat;
  assign pin_out = out_lat;
  assign ibf     = ibf_q;
  assign obf_n   = obf_q;
  assign intr    = intr_q & ie_q;

  assert_latch_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!dir_out && !dir_q && !s_stb) |-> rd_data == $past(pin_in));

  assert_ibf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!dir_out && !dir_q && !s_stb) |-> ibf);

  assert_ibf_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!dir_out && !dir_q && s_stb && rd_rise) |-> !ibf);

  assert_intr_rdfall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!dir_out && rd_fall) |-> !intr);

  assert_obf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dir_out && dir_q && wr_rise) |-> !obf_n && pin_out == $past(cpu_wdata));

  assert_obf_rel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dir_out && !s_ack && !wr_rise) |-> obf_n);

  assert_intr_wrfall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dir_out && wr_fall) |-> !intr);

  assert_ie_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ie_off) |-> !intr && !ie_q);

  assert_mode_in_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!dir_out) |-> obf_n);

  assert_mode_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dir_out) |-> !ibf);

endmodule

// File: tb/strobe_port_hs_bench.sv
`timescale 1ns/1ps
module strobe_port_hs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_out = 1'b0, stb_n = 1'b1, ack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic ie_we = 1'b0, ie_d = 1'b0;
  logic [7:0] pin_in = 8'h00, cpu_wdata = 8'h00;
  logic [7:0] rd_data, pin_out;
  logic ibf, obf_n, intr, ie_q;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] last_in;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strobe_port_hs u_strobe_port_hs (
    .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .stb_n(stb_n), .ack_n(ack_n),
    .rd_n(rd_n), .wr_n(wr_n), .ie_we(ie_we), .ie_d(ie_d), .pin_in(pin_in),
    .cpu_wdata(cpu_wdata), .rd_data(rd_data), .pin_out(pin_out), .ibf(ibf),
    .obf_n(obf_n), .intr(intr), .ie_q(ie_q)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_ie(input logic v);
    ie_d = v; ie_we = 1'b1;
    step(1);
    ie_we = 1'b0;
    step(2);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 ibf", ibf, 0);
    chk("R1 obf_n", obf_n, 1);
    chk("R1 intr", intr, 0);
    chk("R1 ie_q", ie_q, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 pin_out", pin_out, 0);

    for (int i = 0; i < 16; i++) begin
      logic [7:0] pat;
      logic ie;
      pat = 8'((i * 37 + 11) & 255);
      ie = i[0];
      set_ie(ie);
      pin_in = pat; stb_n = 1'b0;
      step(2);
      chk("R11 ibf not yet", ibf, 0);
      step(1);
      chk("R11 ibf third edge", ibf, 1);
      chk("R2 rd_data", rd_data, pat);
      stb_n = 1'b1;
      step(4);
      chk("R4 intr set", intr, ie);
      rd_n = 1'b0;
      step(4);
      chk("R4 intr cleared by read fall", intr, 0);
      chk("R3 ibf held during read", ibf, 1);
      rd_n = 1'b1;
      step(4);
      chk("R3 ibf cleared by read rise", ibf, 0);
      chk("R4 intr stays low", intr, 0);
      last_in = pat;
    end

    set_ie(1'b1);
    pin_in = 8'h3C; stb_n = 1'b0; step(4); stb_n = 1'b1; step(4);
    pin_in = 8'hC3; stb_n = 1'b0; step(4); stb_n = 1'b1; step(4);
    chk("R5 overwrite data", rd_data, 8'hC3);
    chk("R5 ibf stays", ibf, 1);

    rd_n = 1'b0; step(4);
    pin_in = 8'h5A; rd_n = 1'b1; stb_n = 1'b0;
    step(4);
    chk("R3 strobe beats read rise", ibf, 1);
    chk("R2 collision data", rd_data, 8'h5A);
    stb_n = 1'b1; step(4);
    chk("R4 intr after collision", intr, 1);

    ie_d = 1'b0; ie_we = 1'b1;
    step(1);
    ie_we = 1'b0;
    chk("R9 intr off", intr, 0);
    chk("R9 ie_q off", ie_q, 0);
    chk("R9 ibf kept", ibf, 1);
    step(4);
    chk("R9 intr stays off", intr, 0);
    last_in = 8'h5A;

    dir_out = 1'b1;
    step(2);
    chk("R10 ibf cleared on mode change", ibf, 0);

    for (int i = 0; i < 16; i++) begin
      logic [7:0] pat;
      logic ie;
      pat = 8'((i * 53 + 7) & 255);
      ie = i[0];
      set_ie(ie);
      step(3);
      chk("R8 idle intr", intr, ie);
      cpu_wdata = pat; wr_n = 1'b0;
      step(4);
      chk("R8 intr cleared by write fall", intr, 0);
      chk("R6 obf_n before rise", obf_n, 1);
      wr_n = 1'b1;
      step(2);
      chk("R11 obf_n not yet", obf_n, 1);
      step(1);
      chk("R6 obf_n asserted", obf_n, 0);
      chk("R6 pin_out", pin_out, pat);
      step(1);
      chk("R8 intr low while full", intr, 0);
      ack_n = 1'b0;
      step(4);
      chk("R7 obf_n released", obf_n, 1);
      chk("R8 intr low during ack", intr, 0);
      ack_n = 1'b1;
      step(4);
      chk("R8 intr after ack", intr, ie);
    end

    wr_n = 1'b0; step(4);
    cpu_wdata = 8'hA5; wr_n = 1'b1; ack_n = 1'b0;
    step(3);
    chk("R7 write beats ack", obf_n, 0);
    chk("R6 collision data", pin_out, 8'hA5);
    step(1);
    chk("R7 ack releases next cycle", obf_n, 1);
    ack_n = 1'b1; step(4);

    pin_in = 8'hE1; stb_n = 1'b0; step(4); stb_n = 1'b1; step(2);
    chk("R10 strobe ignored ibf", ibf, 0);
    chk("R10 strobe ignored data", rd_data, last_in);

    set_ie(1'b1);
    step(3);
    chk("R8 intr before mode change", intr, 1);
    dir_out = 1'b0;
    step(2);
    chk("R10 obf_n idle in input", obf_n, 1);
    chk("R10 intr cleared on mode change", intr, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule